// File: doc/BRIEF.md
# Data-Side Load/Store Unit with Precise Fault Codes

This unit sits between a processor's execute stage and a valid/ready data-memory bus. The execute stage presents one memory operation at a time: load or store, access size, signed or unsigned load type, the effective byte address and the store data. The unit holds the core stalled while it works. For a store it places the data in the byte lanes picked by the address and marks those lanes with a 4-bit strobe. For a load it moves the addressed bytes down to bit 0 and extends them to 32 bits.

Faults are reported as precise exception causes, not as raw bus errors. The size and the low address bits are checked before anything goes on the bus, so an access that is known to trap never starts a bus transaction. A bus error coming back with the response is turned into a load or a store access-fault code. Every fault carries the effective address, which the core keeps as its trap value.

A small state machine sequences the work. `IDLE` waits for an operation. On `IDLE -> DONE` a misaligned operation finishes at once with its fault. On `IDLE -> ISSUE` an aligned operation is latched. `ISSUE` holds the request until ready is seen, and `ISSUE -> WAIT` is taken on the handshake. `WAIT` waits for the response, and `WAIT -> DONE` captures its data and error flag. `DONE` signals completion for one cycle and always returns to `IDLE`.

Top module: `lsu_core`

## Requirements
- R1: After reset no request is valid, completion and exception are low, and stall is low while no operation is offered.
- R2: Size code 00 is a byte, 01 a halfword and 10 a word. A store drives a strobe of 0001 shifted left by address bits 1:0 for a byte, 0011 shifted left by those bits for a halfword, and 1111 for a word. Each strobed lane i carries store-data byte (i minus address bits 1:0).
- R3: A load shifts the response word right by 8 times address bits 1:0. A byte load then keeps bits 7:0 and a halfword load keeps bits 15:0, each zero-extended when the unsigned flag is 1 and sign-extended when it is 0. A word load returns the word as it is.
- R4: A halfword is misaligned when address bit 0 is 1, and a word is misaligned when address bits 1:0 are not 00. A misaligned access issues no bus request and completes with cause 4 for a load or cause 6 for a store.
- R5: A response with the error flag set completes with cause 5 for a load or cause 7 for a store, and load data reads as 0.
- R6: Once raised, the request stays valid with unchanged address, write flag, size, data and strobe until ready is seen. Completion comes only after a response has been received.
- R7: Stall is high from the first cycle an operation is offered until the completion cycle, and low in the completion cycle. Completion lasts exactly one cycle.
- R8: The request carries the operation's full address, write flag and size code. The atomic-op field is always 0, and a load's strobe is 0000.
- R9: Every exception reports the operation's effective address as its trap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is offered; held until completion |
| op_store | input | 1 | 1 for a store, 0 for a load |
| op_size | input | 2 | Access size code (00 byte, 01 halfword, 10 word) |
| op_unsigned | input | 1 | Zero-extend a sub-word load |
| op_addr | input | 32 | Effective byte address |
| op_wdata | input | 32 | Store data, right-aligned |
| stall | output | 1 | Holds the core while the access is in progress |
| done | output | 1 | One-cycle completion flag |
| load_data | output | 32 | Extended load result, valid with done |
| exc_valid | output | 1 | The completed access trapped |
| exc_cause | output | 4 | Exception cause code (4, 5, 6 or 7) |
| exc_tval | output | 32 | Faulting effective address |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus accepts the request |
| req_addr | output | 32 | Bus byte address |
| req_write | output | 1 | Bus write flag |
| req_size | output | 2 | Bus size code |
| req_wdata | output | 32 | Lane-aligned write data |
| req_wstrb | output | 4 | Byte strobes, stores only |
| req_amo | output | 4 | Atomic-op field, always 0 |
| rsp_valid | input | 1 | Bus response valid |
| rsp_rdata | input | 32 | Bus read data |
| rsp_err | input | 1 | Bus reports an access fault |

## Verification
The bench sweeps every combination of load and store, all three sizes, all four byte offsets and both extension types, under three data words. The data words put set and clear sign bits in different lanes, so a wrong shift, a swapped lane or a wrong extension gives a value that differs from the expected one. The offsets split aligned from misaligned accesses for each size. This shows that misaligned accesses never reach the bus and that the cause codes differ between misalignment and bus errors, and between loads and stores. The ready and response delays vary from zero to several cycles, which shows that the request is held stable while it waits and that completion waits for the response.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned OFS_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } lsu_state_e;

    localparam logic [3:0] CAUSE_LD_MISAL = 4'd4;
    localparam logic [3:0] CAUSE_LD_FAULT = 4'd5;
    localparam logic [3:0] CAUSE_ST_MISAL = 4'd6;
    localparam logic [3:0] CAUSE_ST_FAULT = 4'd7;

    function automatic logic misaligned(input logic [1:0] sz, input logic [OFS_W-1:0] ofs);
        unique case (sz)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = ofs[0];
            default: misaligned = (ofs != '0);
        endcase
    endfunction

endpackage

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int unsigned NLANES = LANES
) (
    input  logic                        is_store,
    input  logic [1:0]                  size,
    input  logic [$clog2(NLANES)-1:0]   ofs,
    input  logic [8*NLANES-1:0]         wdata_in,
    output logic [8*NLANES-1:0]         wdata_out,
    output logic [NLANES-1:0]           wstrb
);
    localparam int unsigned OW = $clog2(NLANES);

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        localparam int unsigned HSRC = i % 2;
        logic sel;
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    wdata_out[8*i +: 8] = wdata_in[7:0];
                    sel = (ofs == OW'(i));
                end
                SZ_HALF: begin
                    wdata_out[8*i +: 8] = wdata_in[8*HSRC +: 8];
                    sel = ((ofs >> 1) == OW'(i / 2));
                end
                default: begin
                    wdata_out[8*i +: 8] = wdata_in[8*i +: 8];
                    sel = 1'b1;
                end
            endcase
            wstrb[i] = is_store & sel;
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int unsigned NLANES = LANES
) (
    input  logic [8*NLANES-1:0]         rdata,
    input  logic [$clog2(NLANES)-1:0]   ofs,
    input  logic [1:0]                  size,
    input  logic                        zero_ext,
    output logic [8*NLANES-1:0]         value
);
    localparam int unsigned W = 8 * NLANES;

    logic [W-1:0] shifted;

    always_comb begin
        shifted = rdata >> (8 * ofs);
        unique case (size)
            SZ_BYTE: value = {{(W-8){~zero_ext & shifted[7]}}, shifted[7:0]};
            SZ_HALF: value = {{(W-16){~zero_ext & shifted[15]}}, shifted[15:0]};
            default: value = shifted;
        endcase
    end

endmodule

// File: rtl/lsu_core.sv
module lsu_core
    import lsu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_store,
    input  logic [1:0]        op_size,
    input  logic              op_unsigned,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              stall,
    output logic              done,
    output logic [DATA_W-1:0] load_data,
    output logic              exc_valid,
    output logic [3:0]        exc_cause,
    output logic [ADDR_W-1:0] exc_tval,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_write,
    output logic [1:0]        req_size,
    output logic [DATA_W-1:0] req_wdata,
    output logic [LANES-1:0]  req_wstrb,
    output logic [3:0]        req_amo,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    input  logic              rsp_err
);
    lsu_state_e state, state_nxt;

    logic              r_store, r_uns, r_misal, r_berr;
    logic [1:0]        r_size;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata, r_rdata;
    logic [DATA_W-1:0] lane_wdata, ext_value;
    logic [LANES-1:0]  lane_strb;
    logic              op_misal;

    assign op_misal = misaligned(op_size, op_addr[OFS_W-1:0]);

    // next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (op_valid) state_nxt = op_misal ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (req_ready) state_nxt = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_nxt = ST_DONE;
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // operation and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_store <= 1'b0;
            r_uns   <= 1'b0;
            r_misal <= 1'b0;
            r_berr  <= 1'b0;
            r_size  <= '0;
            r_addr  <= '0;
            r_wdata <= '0;
            r_rdata <= '0;
        end else begin
            if (state == ST_IDLE && op_valid) begin
                r_store <= op_store;
                r_uns   <= op_unsigned;
                r_misal <= op_misal;
                r_berr  <= 1'b0;
                r_size  <= op_size;
                r_addr  <= op_addr;
                r_wdata <= op_wdata;
            end
            if (state == ST_WAIT && rsp_valid) begin
                r_rdata <= rsp_rdata;
                r_berr  <= rsp_err;
            end
        end
    end

    lsu_store_lanes #(.NLANES(LANES)) u_lanes (
        .is_store  (r_store),
        .size      (r_size),
        .ofs       (r_addr[OFS_W-1:0]),
        .wdata_in  (r_wdata),
        .wdata_out (lane_wdata),
        .wstrb     (lane_strb)
    );

    lsu_load_extract #(.NLANES(LANES)) u_extract (
        .rdata    (r_rdata),
        .ofs      (r_addr[OFS_W-1:0]),
        .size     (r_size),
        .zero_ext (r_uns),
        .value    (ext_value)
    );

    // outputs
    always_comb begin
        req_valid = (state == ST_ISSUE);
        req_addr  = r_addr;
        req_write = r_store;
        req_size  = r_size;
        req_wdata = lane_wdata;
        req_wstrb = lane_strb;
        req_amo   = 4'h0;
        done      = (state == ST_DONE);
        stall     = op_valid && (state != ST_DONE);
        exc_valid = done && (r_misal || r_berr);
        if (r_misal) exc_cause = r_store ? CAUSE_ST_MISAL : CAUSE_LD_MISAL;
        else         exc_cause = r_store ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
        if (!exc_valid) exc_cause = 4'h0;
        exc_tval  = exc_valid ? r_addr : '0;
        load_data = (done && !r_store && !exc_valid) ? ext_value : '0;
    end

endmodule

// File: rtl/lsu_core_chk.sv
module lsu_core_chk
    import lsu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              done,
    input logic              exc_valid,
    input logic [3:0]        exc_cause,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [DATA_W-1:0] req_wdata,
    input logic [LANES-1:0]  req_wstrb,
    input logic [3:0]        req_amo
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write)
            && $stable(req_size) && $stable(req_wdata) && $stable(req_wstrb)); // R6

    AST_NO_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !done); // R6

    AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !misaligned(req_size, req_addr[OFS_W-1:0])); // R4

    AST_AMO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_amo == 4'h0); // R8

    AST_LOAD_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |-> req_wstrb == '0); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_UNSTALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !stall); // R7

    AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> exc_cause >= 4'd4 && exc_cause <= 4'd7); // R5

endmodule

bind lsu_core lsu_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .done      (done),
    .exc_valid (exc_valid),
    .exc_cause (exc_cause),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .req_wstrb (req_wstrb),
    .req_amo   (req_amo)
);

// File: tb/lsu_core_tb.sv
module lsu_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_store = 1'b0, op_unsigned = 1'b0;
    logic [1:0]  op_size = 2'b00;
    logic [31:0] op_addr = '0, op_wdata = '0;
    logic        stall, done, exc_valid, req_valid, req_write;
    logic [31:0] load_data, exc_tval, req_addr, req_wdata;
    logic [3:0]  exc_cause, req_wstrb, req_amo;
    logic [1:0]  req_size;
    logic        req_ready = 1'b0, rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [31:0] rsp_rdata = '0;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    lsu_core u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_store(op_store),
        .op_size(op_size), .op_unsigned(op_unsigned), .op_addr(op_addr),
        .op_wdata(op_wdata), .stall(stall), .done(done), .load_data(load_data),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .req_wstrb(req_wstrb), .req_amo(req_amo), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int p);
        case (p)
            0:       pattern = 32'h0EF0_7F81;
            1:       pattern = 32'h7F80_01FF;
            default: pattern = 32'hC3A5_5A3C;
        endcase
    endfunction

    task automatic do_op(input bit st, input logic [1:0] sz, input logic [1:0] lo,
                         input bit uns, input int pat);
        logic [31:0] addr, wd, rd, raw, exp_ld, s_addr, s_wdata, mask;
        logic [3:0]  s_strb, s_amo, exp_strb;
        logic [1:0]  s_size;
        logic        s_write;
        bit mis, berr, seen, acc, gave, fin;
        int rcnt, pcnt, rsp_dly;
        addr = 32'h8000_0100 + 32'(pat * 16) + 32'(lo);
        wd = pattern(pat);
        rd = pattern((pat + 1) % 3);
        mis = (sz == 2'b01 && lo[0]) || (sz == 2'b10 && lo != 2'b00);
        berr = (pat == 2);
        rsp_dly = (int'(lo) + pat) % 3;
        seen = 0; acc = 0; gave = 0; fin = 0; rcnt = 0; pcnt = 0;
        s_addr = '0; s_wdata = '0; s_strb = '0; s_amo = '0; s_size = '0; s_write = 1'b0;
        @(negedge clk);
        op_valid = 1'b1; op_store = st; op_size = sz; op_unsigned = uns;
        op_addr = addr; op_wdata = wd;
        for (int cyc = 0; cyc < 60 && !fin; cyc++) begin
            @(negedge clk);
            rsp_valid = 1'b0; req_ready = 1'b0; rsp_err = 1'b0;
            if (done) begin
                fin = 1;
                chk(!stall, "R7 stall low at completion", 32'(stall), 32'd0);
                if (!mis) chk(gave, "R6 completion only after response", 32'(gave), 32'd1);
            end else begin
                if (!stall) chk(1'b0, "R7 stall while busy", 32'(stall), 32'd1);
                if (req_valid) begin
                    seen = 1;
                    s_addr = req_addr; s_wdata = req_wdata; s_strb = req_wstrb;
                    s_amo = req_amo; s_size = req_size; s_write = req_write;
                    if (rcnt >= pat) begin req_ready = 1'b1; acc = 1; end
                    else rcnt++;
                end else if (acc && !gave) begin
                    if (pcnt >= rsp_dly) begin
                        rsp_valid = 1'b1; rsp_rdata = rd; rsp_err = berr; gave = 1;
                    end else pcnt++;
                end
            end
        end
        if (!fin) chk(1'b0, "watchdog: operation never completed", 32'd0, 32'd1);
        if (mis) begin
            chk(!seen, "R4 no bus request on misalignment", 32'(seen), 32'd0);
            chk(exc_valid && exc_cause == (st ? 4'd6 : 4'd4), "R4 misaligned cause",
                {27'd0, exc_valid, exc_cause}, {28'd1, st ? 4'd6 : 4'd4});
            chk(exc_tval == addr, "R9 trap value", exc_tval, addr);
        end else begin
            chk(seen, "R6 request issued", 32'(seen), 32'd1);
            chk(s_addr == addr && s_write == st && s_size == sz, "R8 request fields",
                s_addr, addr);
            chk(s_amo == 4'h0, "R8 atomic field zero", 32'(s_amo), 32'd0);
            if (st) begin
                case (sz)
                    2'b00:   exp_strb = 4'b0001 << lo;
                    2'b01:   exp_strb = 4'b0011 << lo;
                    default: exp_strb = 4'b1111;
                endcase
                chk(s_strb == exp_strb, "R2 store strobe", 32'(s_strb), 32'(exp_strb));
                mask = '0;
                for (int i = 0; i < 4; i++) if (exp_strb[i]) mask[8*i +: 8] = 8'hFF;
                chk((s_wdata & mask) == ((wd << (8 * lo)) & mask), "R2 store lanes",
                    s_wdata & mask, (wd << (8 * lo)) & mask);
            end else begin
                chk(s_strb == 4'h0, "R8 load strobe zero", 32'(s_strb), 32'd0);
            end
            if (berr) begin
                chk(exc_valid && exc_cause == (st ? 4'd7 : 4'd5), "R5 bus fault cause",
                    {27'd0, exc_valid, exc_cause}, {28'd1, st ? 4'd7 : 4'd5});
                chk(exc_tval == addr, "R9 trap value", exc_tval, addr);
                if (!st) chk(load_data == '0, "R5 faulted load data", load_data, 32'd0);
            end else begin
                chk(!exc_valid, "R5 no exception on clean access", 32'(exc_valid), 32'd0);
                if (!st) begin
                    raw = rd >> (8 * lo);
                    case (sz)
                        2'b00:   exp_ld = uns ? {24'd0, raw[7:0]} : {{24{raw[7]}}, raw[7:0]};
                        2'b01:   exp_ld = uns ? {16'd0, raw[15:0]} : {{16{raw[15]}}, raw[15:0]};
                        default: exp_ld = raw;
                    endcase
                    chk(load_data == exp_ld, "R3 load extract", load_data, exp_ld);
                end
            end
        end
        op_valid = 1'b0;
        @(negedge clk);
        chk(!done, "R7 completion is one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!req_valid, "R1 request idle after reset", 32'(req_valid), 32'd0);
        chk(!done && !exc_valid, "R1 no completion after reset", 32'(done), 32'd0);
        chk(!stall, "R1 no stall without operation", 32'(stall), 32'd0);
        for (int pat = 0; pat < 3; pat++)
            for (int st = 0; st < 2; st++)
                for (int sz = 0; sz < 3; sz++)
                    for (int lo = 0; lo < 4; lo++)
                        for (int u = 0; u < 2; u++)
                            do_op(st[0], 2'(sz), 2'(lo), u[0], pat);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule